// File: doc/BRIEF.md
# Host-Loaded Frame Staging Bridge

This block connects a host bus target port, the kind that only answers single register writes and reads, to an 8-bit pixel processing core. The host pushes one frame into the block as 32-bit writes to a fixed pixel port. Each write carries four pixels, and the least significant byte is the earliest pixel. The block keeps a running byte count that the host can read at any time.

Processing starts in one of two ways. It starts by itself once the count reaches the frame size, or earlier when the host writes a doorbell register; in that case only the bytes already received make up the frame. The block then streams the stored pixels to the core, one byte per valid/ready transfer. It writes each processed byte back into the same buffer. When as many results as input bytes have come back, it raises an interrupt. The host reads the results through an address window, then writes a clear bit that drops the interrupt and rearms the block for the next frame. The block never masters the bus.

At the default 320 by 240 frame and one byte per clock, a frame passes through the core in about 77,000 cycles. That leaves ample margin for more than 50 frames per second.

Top module: `frame_stage_bridge`

## Requirements
- R1: After reset the status reads 0 (idle, no overrun, no interrupt), the byte and result counts read 0, the interrupt is low and no pixel is offered to the core.
- R2: A host write to word address 0 stores four pixels, byte 0 (bits 7:0) first, and adds 4 to the byte count, which reads at word address 1.
- R3: When the byte count reaches FRAME_W*FRAME_H, processing starts without any doorbell, and exactly that many bytes are offered to the core.
- R4: A host write to word address 1 (doorbell) in idle or loading starts processing of the bytes received so far; a doorbell with zero bytes completes at once.
- R5: Pixels go to the core in write order. While valid is high and ready is low, valid and the data stay unchanged.
- R6: A result byte is accepted only when it does not overtake the input stream. Result byte n reads at word address 0x8000 + n/4, lane n%4, least significant first. The result count reads at word address 2.
- R7: The interrupt rises when the result count equals the frame length and stays high until cleared.
- R8: A host write to word address 2 with bit 0 set clears the interrupt, the counts and the overrun flag and returns to idle; with bit 0 clear it has no effect.
- R9: Pixel and doorbell writes during processing or after completion are dropped and set the overrun flag; the byte count and the state do not change.
- R10: Status at word address 0 holds the state in bits 1:0 (0 idle, 1 loading, 2 processing, 3 done), the overrun flag in bit 2 and the interrupt in bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_en | input | 1 | Host target write strobe |
| host_wr_addr | input | ADDR_W | Host write word address |
| host_wr_data | input | 32 | Host write data |
| host_rd_en | input | 1 | Host target read strobe |
| host_rd_addr | input | ADDR_W | Host read word address |
| host_rd_data | output | 32 | Read data, valid the cycle after the strobe |
| irq | output | 1 | Frame-complete interrupt request |
| core_in_valid | output | 1 | Pixel offered to the core |
| core_in_ready | input | 1 | Core accepts the pixel |
| core_in_data | output | 8 | Pixel to the core |
| core_out_valid | input | 1 | Core offers a result byte |
| core_out_ready | output | 1 | Block accepts the result byte |
| core_out_data | input | 8 | Result byte from the core |

## Verification
The bench builds the bridge with a 4 by 4 frame and 8-byte buffer entries. A self-started frame is then only four host writes long, and every frame crosses a buffer entry boundary. Under random ready and valid stalls, this makes the whole set of cases reachable in a few hundred cycles: auto start, a short frame started by doorbell, a zero-length doorbell, writes dropped while busy or done, and clear-and-rearm.

// File: rtl/fsb_pkg.sv
package fsb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROC = 2'd2,
    ST_DONE = 2'd3
  } fsb_state_e;

  // host write word addresses
  localparam int unsigned WADR_PIXEL = 0;
  localparam int unsigned WADR_START = 1;
  localparam int unsigned WADR_CTRL  = 2;

  // host read word addresses (result window selected by the address MSB)
  localparam int unsigned RADR_STATUS  = 0;
  localparam int unsigned RADR_BYTES   = 1;
  localparam int unsigned RADR_RESULTS = 2;

endpackage

// File: rtl/fsb_frame_buf.sv
// Shared frame store: host word writes, stream byte reads, in-place result
// byte writes and host word reads. Wide entries keep the array shallow.
module fsb_frame_buf #(
  parameter int unsigned FRAME_BYTES = 76800,
  parameter int unsigned CNT_W       = 17,
  parameter int unsigned ENTRY_LG2   = 5
) (
  input  logic               clk,
  input  logic               host_we,
  input  logic [CNT_W-3:0]   host_widx,
  input  logic [31:0]        host_wdata,
  input  logic [CNT_W-1:0]   pix_byte,
  output logic [7:0]         pix_data,
  input  logic               res_we,
  input  logic [CNT_W-1:0]   res_byte,
  input  logic [7:0]         res_data,
  input  logic [CNT_W-3:0]   host_ridx,
  output logic [31:0]        host_rword
);

  localparam int unsigned ENTRY_BYTES = 1 << ENTRY_LG2;
  localparam int unsigned DEPTH       = (FRAME_BYTES + ENTRY_BYTES - 1) / ENTRY_BYTES;
  localparam int unsigned IX_W        = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned WL_W        = ENTRY_LG2 - 2;  // ENTRY_LG2 >= 3

  logic [ENTRY_BYTES*8-1:0] mem [DEPTH];

  logic [IX_W-1:0]      w_ent, p_ent, r_ent, h_ent;
  logic [WL_W-1:0]      w_lane, h_lane;
  logic [ENTRY_LG2-1:0] p_lane, r_lane;

  always_comb begin
    w_ent  = IX_W'(host_widx >> WL_W);
    w_lane = host_widx[WL_W-1:0];
    p_ent  = IX_W'(pix_byte >> ENTRY_LG2);
    p_lane = pix_byte[ENTRY_LG2-1:0];
    r_ent  = IX_W'(res_byte >> ENTRY_LG2);
    r_lane = res_byte[ENTRY_LG2-1:0];
    h_ent  = IX_W'(host_ridx >> WL_W);
    h_lane = host_ridx[WL_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (host_we) mem[w_ent][w_lane*32 +: 32] <= host_wdata;
    if (res_we)  mem[r_ent][r_lane*8 +: 8]   <= res_data;
  end

  assign pix_data   = mem[p_ent][p_lane*8 +: 8];
  assign host_rword = mem[h_ent][h_lane*32 +: 32];

endmodule

// File: rtl/fsb_ctrl.sv
// Frame sequencer: byte counting, start decision, stream and result
// counters, interrupt and overrun flag.
module fsb_ctrl
  import fsb_pkg::*;
#(
  parameter int unsigned FRAME_BYTES = 76800,
  parameter int unsigned CNT_W       = 17,
  parameter int unsigned ADDR_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_clr_bit,
  input  logic              core_in_ready,
  input  logic              core_out_valid,
  output fsb_state_e        state,
  output logic [CNT_W-1:0]  byte_cnt,
  output logic [CNT_W-1:0]  sent_cnt,
  output logic [CNT_W-1:0]  res_cnt,
  output logic              irq,
  output logic              overrun,
  output logic              core_in_valid,
  output logic              core_out_ready,
  output logic              pix_accept,
  output logic              res_store
);

  localparam logic [CNT_W:0] FRAME_X = (CNT_W+1)'(FRAME_BYTES);

  fsb_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, sent_q, sent_d, res_q, res_d, len_q, len_d;
  logic             irq_q, irq_d, ovr_q, ovr_d;
  logic             pix_wr, start_wr, clr, fire_in, fire_out, len_en;
  logic [CNT_W:0]   cnt_plus;

  // next-state process
  always_comb begin
    pix_wr   = wr_en && (wr_addr == ADDR_W'(WADR_PIXEL));
    start_wr = wr_en && (wr_addr == ADDR_W'(WADR_START));
    clr      = wr_en && (wr_addr == ADDR_W'(WADR_CTRL)) && wr_clr_bit;
    core_in_valid  = (state_q == ST_PROC) && (sent_q < len_q);
    core_out_ready = (state_q == ST_PROC) && (res_q < sent_q);
    fire_in  = core_in_valid && core_in_ready;
    fire_out = core_out_ready && core_out_valid;
    cnt_plus = {1'b0, cnt_q} + (CNT_W+1)'(4);

    state_d = state_q;
    cnt_d   = cnt_q;
    sent_d  = sent_q;
    res_d   = res_q;
    len_d   = len_q;
    len_en  = 1'b0;
    irq_d   = irq_q;
    ovr_d   = ovr_q;
    pix_accept = 1'b0;

    if (clr) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
      sent_d  = '0;
      res_d   = '0;
      irq_d   = 1'b0;
      ovr_d   = 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_LOAD: begin
          if (pix_wr) begin
            pix_accept = 1'b1;
            cnt_d      = cnt_plus[CNT_W-1:0];
            state_d    = ST_LOAD;
            if (cnt_plus >= FRAME_X) begin
              state_d = ST_PROC;
              len_d   = FRAME_X[CNT_W-1:0];
              len_en  = 1'b1;
            end
          end else if (start_wr) begin
            state_d = ST_PROC;
            len_d   = cnt_q;
            len_en  = 1'b1;
          end
        end
        ST_PROC: begin
          if (pix_wr || start_wr) ovr_d = 1'b1;
          if (fire_in)  sent_d = sent_q + 1'b1;
          if (fire_out) res_d  = res_q + 1'b1;
          if (res_d == len_q) begin
            state_d = ST_DONE;
            irq_d   = 1'b1;
          end
        end
        ST_DONE: begin
          if (pix_wr || start_wr) ovr_d = 1'b1;
        end
        default: ;
      endcase
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sent_q  <= '0;
      res_q   <= '0;
      len_q   <= '0;
      irq_q   <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sent_q  <= sent_d;
      res_q   <= res_d;
      irq_q   <= irq_d;
      ovr_q   <= ovr_d;
      if (len_en) len_q <= len_d;
    end
  end

  assign state     = state_q;
  assign byte_cnt  = cnt_q;
  assign sent_cnt  = sent_q;
  assign res_cnt   = res_q;
  assign irq       = irq_q;
  assign overrun   = ovr_q;
  assign res_store = fire_out;

  // R3: the stream never runs past the frame length
  assert_sent_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sent_q <= len_q) else $error("stream passed frame length");

  // R5: a stalled offer keeps its position
  assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (core_in_valid && !core_in_ready && !clr) |=> (core_in_valid && $stable(sent_q)))
    else $error("stalled pixel dropped");

  // R6: results never overtake the input stream
  assert_res_behind_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_q <= sent_q) else $error("result overtook input");

  // R7: the interrupt holds until a clear
  assert_irq_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !clr) |=> irq_q) else $error("interrupt dropped");

  // R7: the interrupt only accompanies a finished frame
  assert_irq_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (state_q == ST_DONE)) else $error("interrupt outside done");

  // R8: clear returns to idle with counts and interrupt gone
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (state_q == ST_IDLE && !irq_q && cnt_q == '0 && res_q == '0))
    else $error("clear incomplete");

  // R9: busy-time pixel writes leave the count alone and flag overrun
  assert_ignore_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PROC && pix_wr) |=> ($stable(cnt_q) && ovr_q))
    else $error("busy write not ignored");

endmodule

// File: rtl/fsb_readout.sv
// Host read decode with a registered read data port.
module fsb_readout
  import fsb_pkg::*;
#(
  parameter int unsigned CNT_W  = 17,
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  fsb_state_e        state,
  input  logic              overrun,
  input  logic              irq,
  input  logic [CNT_W-1:0]  byte_cnt,
  input  logic [CNT_W-1:0]  res_cnt,
  input  logic [31:0]       buf_word,
  output logic [CNT_W-3:0]  buf_ridx,
  output logic [31:0]       rd_data
);

  logic [31:0] rd_d;

  assign buf_ridx = rd_addr[CNT_W-3:0];

  always_comb begin
    if (rd_addr[ADDR_W-1]) begin
      rd_d = buf_word;
    end else if (rd_addr == ADDR_W'(RADR_STATUS)) begin
      rd_d = {28'd0, irq, overrun, state};
    end else if (rd_addr == ADDR_W'(RADR_BYTES)) begin
      rd_d = 32'(byte_cnt);
    end else if (rd_addr == ADDR_W'(RADR_RESULTS)) begin
      rd_d = 32'(res_cnt);
    end else begin
      rd_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_d;
  end

endmodule

// File: rtl/frame_stage_bridge.sv
module frame_stage_bridge
  import fsb_pkg::*;
#(
  parameter int unsigned FRAME_W   = 320,
  parameter int unsigned FRAME_H   = 240,
  parameter int unsigned ENTRY_LG2 = 5,
  parameter int unsigned ADDR_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_en,
  input  logic [ADDR_W-1:0] host_wr_addr,
  input  logic [31:0]       host_wr_data,
  input  logic              host_rd_en,
  input  logic [ADDR_W-1:0] host_rd_addr,
  output logic [31:0]       host_rd_data,
  output logic              irq,
  output logic              core_in_valid,
  input  logic              core_in_ready,
  output logic [7:0]        core_in_data,
  input  logic              core_out_valid,
  output logic              core_out_ready,
  input  logic [7:0]        core_out_data
);

  localparam int unsigned FRAME_BYTES = FRAME_W * FRAME_H;  // multiple of 4
  localparam int unsigned CNT_W       = $clog2(FRAME_BYTES + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ns = rst_sync[1];

  fsb_state_e       state;
  logic [CNT_W-1:0] byte_cnt, sent_cnt, res_cnt;
  logic             overrun, pix_accept, res_store;
  logic [CNT_W-3:0] ridx;
  logic [31:0]      buf_word;
  logic             clr_req;

  fsb_ctrl #(.FRAME_BYTES(FRAME_BYTES), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_ns),
    .wr_en(host_wr_en), .wr_addr(host_wr_addr), .wr_clr_bit(host_wr_data[0]),
    .core_in_ready(core_in_ready), .core_out_valid(core_out_valid),
    .state(state), .byte_cnt(byte_cnt), .sent_cnt(sent_cnt), .res_cnt(res_cnt),
    .irq(irq), .overrun(overrun),
    .core_in_valid(core_in_valid), .core_out_ready(core_out_ready),
    .pix_accept(pix_accept), .res_store(res_store)
  );

  fsb_frame_buf #(.FRAME_BYTES(FRAME_BYTES), .CNT_W(CNT_W), .ENTRY_LG2(ENTRY_LG2)) u_buf (
    .clk(clk),
    .host_we(pix_accept), .host_widx(byte_cnt[CNT_W-1:2]), .host_wdata(host_wr_data),
    .pix_byte(sent_cnt), .pix_data(core_in_data),
    .res_we(res_store), .res_byte(res_cnt), .res_data(core_out_data),
    .host_ridx(ridx), .host_rword(buf_word)
  );

  fsb_readout #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst_n(rst_ns),
    .rd_en(host_rd_en), .rd_addr(host_rd_addr),
    .state(state), .overrun(overrun), .irq(irq),
    .byte_cnt(byte_cnt), .res_cnt(res_cnt),
    .buf_word(buf_word), .buf_ridx(ridx), .rd_data(host_rd_data)
  );

  assign clr_req = host_wr_en && (host_wr_addr == ADDR_W'(WADR_CTRL)) && host_wr_data[0];

  // R5: stalled pixel data is held at the port
  assert_pix_stable_R5: assert property (@(posedge clk) disable iff (!rst_ns)
    (core_in_valid && !core_in_ready && !clr_req) |=> $stable(core_in_data))
    else $error("stalled pixel data changed");

endmodule

// File: tb/frame_stage_bridge_bench.sv
module frame_stage_bridge_bench;

  localparam int FW = 4, FH = 4, FB = FW * FH, LG = 3, AW = 16;
  localparam logic [AW-1:0] WIN = 16'h8000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n;
  logic          host_wr_en, host_rd_en;
  logic [AW-1:0] host_wr_addr, host_rd_addr;
  logic [31:0]   host_wr_data, host_rd_data;
  logic          irq, core_in_valid, core_in_ready, core_out_valid, core_out_ready;
  logic [7:0]    core_in_data, core_out_data;

  frame_stage_bridge #(.FRAME_W(FW), .FRAME_H(FH), .ENTRY_LG2(LG), .ADDR_W(AW)) u_frame_stage_bridge (
    .clk(clk), .rst_n(rst_n),
    .host_wr_en(host_wr_en), .host_wr_addr(host_wr_addr), .host_wr_data(host_wr_data),
    .host_rd_en(host_rd_en), .host_rd_addr(host_rd_addr), .host_rd_data(host_rd_data),
    .irq(irq),
    .core_in_valid(core_in_valid), .core_in_ready(core_in_ready), .core_in_data(core_in_data),
    .core_out_valid(core_out_valid), .core_out_ready(core_out_ready), .core_out_data(core_out_data)
  );

  int compared = 0, mismatched = 0;
  bit finished = 0;

  // behavioural reference
  int m_state, m_cnt, m_len, m_sent, m_res;
  bit m_irq, m_ovr;
  byte unsigned m_pix[FB];
  byte unsigned m_out[FB];
  byte unsigned coreq[$];
  bit ov_hold;
  int stall;

  function automatic byte unsigned alg(byte unsigned x);
    return byte'(x * 3 + 7);
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(logic [AW-1:0] ra);
    int i;
    if (ra[AW-1]) begin
      i = int'(ra[AW-2:0]) * 4;
      if (i + 3 < FB) return {m_out[i+3], m_out[i+2], m_out[i+1], m_out[i]};
      return 32'h0;
    end
    case (ra)
      16'd0:   return {28'd0, m_irq, m_ovr, 2'(m_state)};
      16'd1:   return 32'(m_cnt);
      16'd2:   return 32'(m_res);
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_step(bit we, logic [AW-1:0] wa, logic [31:0] wd, bit fi, bit fo,
                            byte unsigned dout);
    bit pw, sw;
    pw = we && wa == 16'd0;
    sw = we && wa == 16'd1;
    if (we && wa == 16'd2 && wd[0]) begin
      m_state = 0; m_cnt = 0; m_sent = 0; m_res = 0; m_irq = 0; m_ovr = 0;
      return;
    end
    case (m_state)
      0, 1: begin
        if (pw) begin
          for (int b = 0; b < 4; b++) m_pix[m_cnt + b] = wd[8*b +: 8];
          m_cnt += 4;
          m_state = 1;
          if (m_cnt >= FB) begin m_state = 2; m_len = FB; end
        end else if (sw) begin
          m_state = 2; m_len = m_cnt;
        end
      end
      2: begin
        if (pw || sw) m_ovr = 1;
        if (fi) m_sent++;
        if (fo) begin m_out[m_res] = dout; m_res++; end
        if (m_res == m_len) begin m_state = 3; m_irq = 1; end
      end
      default: if (pw || sw) m_ovr = 1;
    endcase
  endtask

  // one clock: drive at the falling edge, compare at the next falling edge
  task automatic cyc(bit we, logic [AW-1:0] wa, logic [31:0] wd,
                     bit re, logic [AW-1:0] ra, string rtag);
    logic [31:0]  exp_rd;
    bit           fi, fo, exp_iv;
    byte unsigned din, dout;
    host_wr_en = we; host_wr_addr = wa; host_wr_data = wd;
    host_rd_en = re; host_rd_addr = ra;
    core_in_ready = (stall == 0) ? 1'b1 : ($urandom_range(0, 1) == 1);
    if (!ov_hold) begin
      if (coreq.size() > 0 && (stall == 0 || $urandom_range(0, 2) != 0)) begin
        core_out_valid = 1'b1; core_out_data = coreq[0];
      end else begin
        core_out_valid = 1'b0; core_out_data = 8'h00;
      end
    end
    #1;
    fi = core_in_valid && core_in_ready;
    din = core_in_data;
    fo = core_out_valid && core_out_ready;
    dout = core_out_data;
    exp_rd = model_read(ra);
    model_step(we, wa, wd, fi, fo, dout);
    if (fi) coreq.push_back(alg(din));
    if (fo) begin void'(coreq.pop_front()); ov_hold = 1'b0; end
    else ov_hold = core_out_valid;
    @(posedge clk);
    @(negedge clk);
    exp_iv = (m_state == 2) && (m_sent < m_len);
    chk("R7", "irq", 32'(irq), 32'(m_irq));
    chk("R3", "core_in_valid", 32'(core_in_valid), 32'(exp_iv));
    if (exp_iv) chk("R5", "core_in_data", 32'(core_in_data), 32'(m_pix[m_sent]));
    chk("R6", "core_out_ready", 32'(core_out_ready), 32'((m_state == 2) && (m_res < m_sent)));
    if (re) chk(rtag, "host_rd_data", host_rd_data, exp_rd);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) cyc(0, 16'd0, 32'd0, 0, 16'd0, "");
  endtask

  task automatic wait_done();
    for (int k = 0; k < 400 && m_state != 3; k++) cyc(0, 16'd0, 32'd0, 0, 16'd0, "");
    chk("R7", "frame completed", 32'(m_state), 32'd3);
  endtask

  task automatic rd(logic [AW-1:0] a, string tag);
    cyc(0, 16'd0, 32'd0, 1, a, tag);
  endtask

  task automatic clear();
    cyc(1, 16'd2, 32'd1, 0, 16'd0, "");
  endtask

  initial begin
    host_wr_en = 0; host_wr_addr = '0; host_wr_data = '0;
    host_rd_en = 0; host_rd_addr = '0;
    core_in_ready = 0; core_out_valid = 0; core_out_data = '0;
    m_state = 0; m_cnt = 0; m_len = 0; m_sent = 0; m_res = 0; m_irq = 0; m_ovr = 0;
    ov_hold = 0; stall = 1;
    for (int i = 0; i < FB; i++) begin m_pix[i] = 0; m_out[i] = 0; end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    chk("R1", "irq in reset", 32'(irq), 32'd0);
    chk("R1", "core_in_valid in reset", 32'(core_in_valid), 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd(16'd0, "R1");
    rd(16'd1, "R1");
    rd(16'd2, "R1");

    // frame A: full frame, auto start, random stalls (R2, R3, R5)
    for (int k = 0; k < 4; k++)
      cyc(1, 16'd0, 32'h13243546 + 32'h11111111 * k, 1, 16'd1, "R2");
    cyc(1, 16'd0, 32'hDEADBEEF, 0, 16'd0, "");   // R9: dropped while busy
    rd(16'd1, "R9");
    rd(16'd0, "R9");
    wait_done();
    rd(16'd0, "R10");
    rd(16'd2, "R6");
    for (int i = 0; i < FB / 4; i++) rd(WIN + 16'(i), "R6");
    cyc(1, 16'd1, 32'd0, 0, 16'd0, "");          // R9: doorbell in done
    cyc(1, 16'd0, 32'h01020304, 0, 16'd0, "");   // R9: pixel in done
    rd(16'd1, "R9");
    rd(WIN, "R9");
    cyc(1, 16'd2, 32'd0, 0, 16'd0, "");          // R8: clear bit low
    rd(16'd0, "R8");
    clear();
    rd(16'd0, "R8");
    rd(16'd1, "R8");
    rd(16'd2, "R8");

    // frame B: short frame by doorbell (R4)
    cyc(1, 16'd0, 32'hA0B1C2D3, 0, 16'd0, "");
    rd(16'd0, "R10");
    cyc(1, 16'd0, 32'h0F1E2D3C, 0, 16'd0, "");
    cyc(1, 16'd1, 32'd0, 1, 16'd1, "R4");
    wait_done();
    rd(16'd2, "R4");
    rd(WIN, "R6");
    rd(WIN + 16'd1, "R6");
    clear();
    idle(2);

    // frame C: doorbell with no data (R4)
    cyc(1, 16'd1, 32'd0, 0, 16'd0, "");
    idle(1);
    rd(16'd0, "R4");
    rd(16'd2, "R4");
    clear();

    // frame D: full frame, no stalls
    stall = 0;
    for (int k = 0; k < 4; k++) cyc(1, 16'd0, 32'hF0E1D2C3 - 32'h01020304 * k, 0, 16'd0, "");
    wait_done();
    for (int i = 0; i < FB / 4; i++) rd(WIN + 16'(i), "R6");
    clear();
    rd(16'd0, "R8");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule